// File: doc/BRIEF.md
# Interrupt Entry Context Sequencer

This block carries out the register-level steps that follow once an interrupt request has reached the processor core. It waits for the pipeline to report an instruction boundary and only then takes the request. In that single step it records the source's event code in a readable event register. It also saves the current status word, program counter and stack pointer (R15) into three shadow registers. It then raises three mode bits in the status word and issues a program-counter load toward the handler entry point, which is the vector base plus a fixed offset of 0x600.

The surrounding core supplies the live status word, program counter, R15 and vector base. On the entry strobe it writes the presented status word and program-counter value back into its architectural state. All outputs are registered. Everything written by one entry appears together in the cycle after the accepting clock edge, and it stays there until the next entry.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset every output is zero, including both strobes `sr_wr_o` and `pc_ld_o`.
- R2: An entry is started at a clock edge only when `req_i` and `boundary_i` are both 1 and status bit 28 (block bit) of `sr_i` is 0. Its results and both strobes appear in the cycle after that edge.
- R3: A request with no boundary strobe starts no entry and changes no output, even if the request is withdrawn before a boundary arrives.
- R4: On entry, `evt_o` takes the value of `evt_code_i` sampled at the accepting edge.
- R5: On entry, `ssr_o` takes the sampled `sr_i` and `spc_o` takes the sampled `pc_i`.
- R6: On entry, `sgr_o` takes the sampled stack-pointer value `sp_i`.
- R7: On entry, `sr_o` equals the sampled `sr_i` with bits 30 (privileged mode), 29 (register bank) and 28 (block) forced to 1. Every other bit keeps its sampled value, including the 4-bit interrupt mask at bits 7:4.
- R8: On entry, `pc_o` equals the sampled `vbr_i` plus 0x600, computed modulo 2^32.
- R9: While bit 28 of `sr_i` is 1, a request at a boundary starts no entry and leaves every output unchanged.
- R10: `sr_wr_o` and `pc_ld_o` are asserted together for exactly one cycle per entry. No new entry is accepted at the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Accepted interrupt request from the arbiter |
| evt_code_i | input | 12 | Event code of the winning source |
| boundary_i | input | 1 | Instruction-boundary strobe from the pipeline |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | Current R15 stack pointer |
| vbr_i | input | 32 | Vector base |
| evt_o | output | 12 | Event register |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack pointer |
| sr_o | output | 32 | Status word to write back |
| sr_wr_o | output | 1 | One-cycle status write strobe |
| pc_o | output | 32 | Handler address |
| pc_ld_o | output | 1 | One-cycle program-counter load strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 12-bit event code, an offset of 0x600, mode bits at positions 30, 29 and 28, and the mask field at bits 7:4. With these values, a vector base near the top of the address space makes the handler-address addition wrap, which exercises the modulo rule. A status word that already carries a full mask and scattered low bits shows that only the three mode bits change. Holding request and boundary high for several cycles exercises the one-cycle hold-off after each entry.

// File: rtl/ient_pkg.sv
package ient_pkg;

  localparam int unsigned DEF_XLEN     = 32;
  localparam int unsigned DEF_EVT_W    = 12;
  localparam logic [31:0] DEF_VEC_OFF  = 32'h0000_0600;
  localparam int unsigned DEF_MD_POS   = 30;
  localparam int unsigned DEF_RB_POS   = 29;
  localparam int unsigned DEF_BL_POS   = 28;
  localparam int unsigned DEF_MASK_LSB = 4;
  localparam int unsigned DEF_MASK_W   = 4;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ENTRY = 1'b1
  } seq_state_t;

endpackage

// File: rtl/ient_accept.sv
module ient_accept
  import ient_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic boundary_i,
  input  logic bl_i,
  output logic take_o,
  output logic strobe_o
);

  seq_state_t state_q;

  // A request is taken only at a boundary, with the block bit clear,
  // and never in the cycle in which a previous entry is being written.
  assign take_o = req_i && boundary_i && !bl_i && (state_q == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else begin
      case (state_q)
        SEQ_IDLE:  if (take_o) state_q <= SEQ_ENTRY;
        SEQ_ENTRY: state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign strobe_o = (state_q == SEQ_ENTRY);

  p_entry_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $past(req_i && boundary_i && !bl_i));

  p_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    bl_i |=> !strobe_o);

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);

  p_no_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    !boundary_i |=> !strobe_o);

endmodule

// File: rtl/ient_capreg.sv
module ient_capreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst)        q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(q_o));

endmodule

// File: rtl/ient_sr_pc.sv
module ient_sr_pc #(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] VEC_OFF  = 32'h0000_0600,
  parameter int unsigned MD_POS   = 30,
  parameter int unsigned RB_POS   = 29,
  parameter int unsigned BL_POS   = 28,
  parameter int unsigned MASK_LSB = 4,
  parameter int unsigned MASK_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic [XLEN-1:0] vbr_i,
  output logic [XLEN-1:0] sr_o,
  output logic [XLEN-1:0] pc_o
);

  localparam int unsigned NSET = 3;
  localparam int unsigned SET_POS [NSET] = '{MD_POS, RB_POS, BL_POS};
  localparam logic [XLEN-1:0] OFF = XLEN'(VEC_OFF);

  logic [XLEN-1:0] set_mask;
  logic [XLEN-1:0] sr_next;
  logic [XLEN-1:0] pc_next;
  logic            upd_q;

  for (genvar b = 0; b < XLEN; b++) begin : g_mask
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NSET; k++)
        if (SET_POS[k] == b) hit = 1'b1;
    end
    assign set_mask[b] = hit;
  end

  assign sr_next = sr_i | set_mask;
  assign pc_next = vbr_i + OFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_o  <= '0;
      pc_o  <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= cap_i;
      if (cap_i) begin
        sr_o <= sr_next;
        pc_o <= pc_next;
      end
    end
  end

  p_mask_kept_r7: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> sr_o[MASK_LSB +: MASK_W] == $past(sr_i[MASK_LSB +: MASK_W]));

  p_mode_bits_r7: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> (sr_o[MD_POS] && sr_o[RB_POS] && sr_o[BL_POS]));

  p_pc_target_r8: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> pc_o == $past(vbr_i) + OFF);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ient_pkg::*;
#(
  parameter int unsigned XLEN     = DEF_XLEN,
  parameter int unsigned EVT_W    = DEF_EVT_W,
  parameter logic [31:0] VEC_OFF  = DEF_VEC_OFF,
  parameter int unsigned MD_POS   = DEF_MD_POS,
  parameter int unsigned RB_POS   = DEF_RB_POS,
  parameter int unsigned BL_POS   = DEF_BL_POS,
  parameter int unsigned MASK_LSB = DEF_MASK_LSB,
  parameter int unsigned MASK_W   = DEF_MASK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [EVT_W-1:0] evt_code_i,
  input  logic             boundary_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic [EVT_W-1:0] evt_o,
  output logic [XLEN-1:0]  ssr_o,
  output logic [XLEN-1:0]  spc_o,
  output logic [XLEN-1:0]  sgr_o,
  output logic [XLEN-1:0]  sr_o,
  output logic             sr_wr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             pc_ld_o
);

  localparam int unsigned NSHD = 3;

  logic take;
  logic strobe;

  ient_accept u_accept (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .boundary_i (boundary_i),
    .bl_i       (sr_i[BL_POS]),
    .take_o     (take),
    .strobe_o   (strobe)
  );

  ient_capreg #(.W(EVT_W)) u_evt (
    .clk   (clk),
    .rst   (rst),
    .cap_i (take),
    .d_i   (evt_code_i),
    .q_o   (evt_o)
  );

  // Shadow copies of status word, program counter and stack pointer.
  logic [XLEN-1:0] shd_d [NSHD];
  logic [XLEN-1:0] shd_q [NSHD];

  assign shd_d[0] = sr_i;
  assign shd_d[1] = pc_i;
  assign shd_d[2] = sp_i;

  for (genvar i = 0; i < NSHD; i++) begin : g_shadow
    ient_capreg #(.W(XLEN)) u_shd (
      .clk   (clk),
      .rst   (rst),
      .cap_i (take),
      .d_i   (shd_d[i]),
      .q_o   (shd_q[i])
    );
  end

  assign ssr_o = shd_q[0];
  assign spc_o = shd_q[1];
  assign sgr_o = shd_q[2];

  ient_sr_pc #(
    .XLEN     (XLEN),
    .VEC_OFF  (VEC_OFF),
    .MD_POS   (MD_POS),
    .RB_POS   (RB_POS),
    .BL_POS   (BL_POS),
    .MASK_LSB (MASK_LSB),
    .MASK_W   (MASK_W)
  ) u_sr_pc (
    .clk   (clk),
    .rst   (rst),
    .cap_i (take),
    .sr_i  (sr_i),
    .vbr_i (vbr_i),
    .sr_o  (sr_o),
    .pc_o  (pc_o)
  );

  assign sr_wr_o = strobe;
  assign pc_ld_o = strobe;

  p_saved_status_r5: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (ssr_o == $past(sr_i)) && (spc_o == $past(pc_i)));

  p_saved_stack_r6: assert property (@(posedge clk) disable iff (rst)
    strobe |-> sgr_o == $past(sp_i));

  p_event_r4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> evt_o == $past(evt_code_i));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [31:0] MODE_SET = 32'h7000_0000;
  localparam logic [31:0] OFF = 32'h0000_0600;

  localparam logic [31:0] TV_SR  [NV] = '{32'h0000_0000, 32'h0000_00F0, 32'h8000_0A5C,
                                         32'h4000_0031, 32'h0FFF_FF7E, 32'hE000_0000};
  localparam logic [31:0] TV_PC  [NV] = '{32'h0000_1000, 32'h8C00_2004, 32'hFFFF_FFFE,
                                         32'h1234_5678, 32'h0000_0002, 32'hA000_0000};
  localparam logic [31:0] TV_SP  [NV] = '{32'h8FFF_FFF0, 32'h0000_0000, 32'h5555_AAAA,
                                         32'hDEAD_BEEF, 32'h0C00_0100, 32'hFFFF_FFFF};
  localparam logic [31:0] TV_VBR [NV] = '{32'h0000_0000, 32'h8C00_0000, 32'hFFFF_FC00,
                                         32'h1000_0A00, 32'hFFFF_FFFF, 32'h0000_0100};
  localparam logic [11:0] TV_EVT [NV] = '{12'h200, 12'h5A0, 12'hFFF, 12'h000, 12'h3E0, 12'h820};

  logic        clk = 1'b0;
  logic        rst;
  logic        req_i = 1'b0;
  logic [11:0] evt_code_i = '0;
  logic        boundary_i = 1'b0;
  logic [31:0] sr_i = '0, pc_i = '0, sp_i = '0, vbr_i = '0;
  logic [11:0] evt_o;
  logic [31:0] ssr_o, spc_o, sgr_o, sr_o, pc_o;
  logic        sr_wr_o, pc_ld_o;

  int n_checks = 0;
  int n_errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .evt_code_i(evt_code_i),
    .boundary_i(boundary_i), .sr_i(sr_i), .pc_i(pc_i), .sp_i(sp_i), .vbr_i(vbr_i),
    .evt_o(evt_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o), .sr_o(sr_o),
    .sr_wr_o(sr_wr_o), .pc_o(pc_o), .pc_ld_o(pc_ld_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic [31:0] s, input logic [31:0] p, input logic [31:0] q,
                        input logic [31:0] v, input logic [11:0] e);
    sr_i = s; pc_i = p; sp_i = q; vbr_i = v; evt_code_i = e;
  endtask

  // Drives one entry at the next edge and checks the results one cycle later.
  task automatic entry_and_check(input logic [31:0] s, input logic [31:0] p, input logic [31:0] q,
                                 input logic [31:0] v, input logic [11:0] e);
    @(negedge clk);
    set_in(s, p, q, v, e);
    req_i = 1'b1; boundary_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0; boundary_i = 1'b0;
    chk(sr_wr_o && pc_ld_o, "R2 strobes", {30'd0, sr_wr_o, pc_ld_o}, 32'd3);
    chk(evt_o == e, "R4 event", {20'd0, evt_o}, {20'd0, e});
    chk(ssr_o == s, "R5 ssr", ssr_o, s);
    chk(spc_o == p, "R5 spc", spc_o, p);
    chk(sgr_o == q, "R6 sgr", sgr_o, q);
    chk(sr_o == (s | MODE_SET), "R7 sr", sr_o, s | MODE_SET);
    chk(pc_o == v + OFF, "R8 pc", pc_o, v + OFF);
    @(negedge clk);
    chk(!sr_wr_o && !pc_ld_o, "R10 strobe width", {30'd0, sr_wr_o, pc_ld_o}, 32'd0);
  endtask

  task automatic check_unchanged(input string tag, input logic [31:0] ssr_e, input logic [31:0] pc_e,
                                 input logic [11:0] evt_e);
    chk(!sr_wr_o && !pc_ld_o, {tag, " strobes"}, {30'd0, sr_wr_o, pc_ld_o}, 32'd0);
    chk(ssr_o == ssr_e, {tag, " ssr"}, ssr_o, ssr_e);
    chk(pc_o == pc_e, {tag, " pc"}, pc_o, pc_e);
    chk(evt_o == evt_e, {tag, " evt"}, {20'd0, evt_o}, {20'd0, evt_e});
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(evt_o == 0 && ssr_o == 0 && spc_o == 0 && sgr_o == 0, "R1 shadows", ssr_o | spc_o | sgr_o, 32'd0);
    chk(sr_o == 0 && pc_o == 0, "R1 sr/pc", sr_o | pc_o, 32'd0);
    chk(!sr_wr_o && !pc_ld_o, "R1 strobes", {30'd0, sr_wr_o, pc_ld_o}, 32'd0);
    rst = 1'b0;

    // Table walk: R2, R4..R8, R10
    for (int i = 0; i < NV; i++)
      entry_and_check(TV_SR[i], TV_PC[i], TV_SP[i], TV_VBR[i], TV_EVT[i]);

    // R3: request without boundary, then withdrawn before the boundary
    @(negedge clk);
    set_in(32'h0000_0010, 32'h1111_1111, 32'h2222_2222, 32'h3333_0000, 12'h111);
    req_i = 1'b1; boundary_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_unchanged("R3 no boundary", TV_SR[NV-1], TV_VBR[NV-1] + OFF, TV_EVT[NV-1]);
    end
    req_i = 1'b0; boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0;
    check_unchanged("R3 withdrawn", TV_SR[NV-1], TV_VBR[NV-1] + OFF, TV_EVT[NV-1]);

    // R9: block bit set
    @(negedge clk);
    set_in(32'h1000_00F0, 32'h4444_4444, 32'h5555_5555, 32'h6666_0000, 12'h222);
    req_i = 1'b1; boundary_i = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check_unchanged("R9 blocked", TV_SR[NV-1], TV_VBR[NV-1] + OFF, TV_EVT[NV-1]);
    end
    req_i = 1'b0; boundary_i = 1'b0;

    // R10: request and boundary held high with block bit clear
    @(negedge clk);
    set_in(32'h0000_0070, 32'h0000_8000, 32'h0000_9000, 32'h0001_0000, 12'h7C0);
    req_i = 1'b1; boundary_i = 1'b1;
    @(negedge clk);
    chk(sr_wr_o && pc_ld_o, "R10 first entry", {30'd0, sr_wr_o, pc_ld_o}, 32'd3);
    set_in(32'h0000_0020, 32'h0000_A000, 32'h0000_B000, 32'h0002_0000, 12'h7E0);
    @(negedge clk);
    chk(!sr_wr_o && !pc_ld_o, "R10 hold-off", {30'd0, sr_wr_o, pc_ld_o}, 32'd0);
    chk(pc_o == 32'h0001_0600, "R10 hold-off pc", pc_o, 32'h0001_0600);
    @(negedge clk);
    req_i = 1'b0; boundary_i = 1'b0;
    chk(sr_wr_o && pc_o == 32'h0002_0600, "R10 next entry", pc_o, 32'h0002_0600);
    @(negedge clk);
    chk(!sr_wr_o, "R10 end", {31'd0, sr_wr_o}, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule